// File: doc/BRIEF.md
# Memory Protection Entry Register File

This block stores the settings of a set of memory protection entries: one configuration byte and one address register per entry, and a single security configuration register. Software reaches them through one control-register style port. A two-bit kind code and an index select the target, writes complete on the clock edge, and reads return combinationally. The configuration bytes are packed several to a register, so one register write can update several entries at once.

Writes that the lock rules forbid are dropped silently. A locked entry keeps both its configuration byte and its address. An entry that is locked and set to top-of-range mode also freezes the address register of the entry below it, because that address is the base of its range. Indices past the implemented entries are ignored on write and read as zero. The security register has two policy bits that cannot be cleared once set. It also has a bypass bit that cannot be newly set while any entry is locked. After every accepted configuration register write, a one-cycle flush pulse tells translation caches to drop their state.

Top module: `pmp_entry_regs`

## Requirements
- R1: Byte i (bits 8i+7:8i) of configuration register k belongs to entry 4k+i. A configuration register holds XLEN/8 bytes, and a read returns those entries' bytes packed in the same layout.
- R2: When XLEN is 64, a write to a configuration register with an odd index changes no entry and raises no flush pulse.
- R3: A configuration byte whose bit 7 (lock) is set does not change on any later write. Other bytes of the same register write are still accepted.
- R4: A write to the address register of a locked entry is dropped.
- R5: A write to the address register of entry n is dropped when entry n+1 is locked and has mode bits [4:3] equal to 01 (top-of-range). Other modes of entry n+1 do not block it, and the last entry has no such neighbour.
- R6: Configuration bytes for entries at or beyond NUM_ENTRIES, and address indices at or beyond NUM_ENTRIES, are ignored on write and read as zero. Kind code 3 reads zero and writes nothing.
- R7: In the security register, bit 0 (lockdown) and bit 1 (whitelist) are sticky. Once written to 1 they stay 1 until reset.
- R8: Security bit 2 (lock bypass) takes the written value, except that while it is 0 and any entry is locked, it stays 0.
- R9: `flushPulse` is high for the single cycle after each clock edge that accepts a configuration register write, whether or not its bytes were locked. Address and security writes do not raise it.
- R10: After reset, every configuration byte, address register and the security register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the selected register |
| csrKind | input | 2 | Target kind: 0 configuration, 1 address, 2 security, 3 none |
| csrIdx | input | $clog2(NUM_ENTRIES)+1 | Register index within the kind |
| wrData | input | XLEN | Write data |
| rdData | output | XLEN | Combinational read data of the selected register |
| flushPulse | output | 1 | One-cycle pulse after an accepted configuration write |

## Verification
The hardest case to reach is the cross-entry freeze. The bench has to lock an upper entry in top-of-range mode through a packed configuration write, then attempt an address write one index below it and see the old value kept. It does the same with the upper entry locked in a different mode and sees the write land. The bypass bit is hard to observe because its gating depends on history. So a second instance with 64-bit registers sets and clears it while no entry is locked. That instance then locks an entry through an even register, after an odd-register write was shown to change nothing, and sees the bit refuse to set.

// File: rtl/pmp_reg_pkg.sv
package pmp_reg_pkg;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csrKind_e;

  localparam int LOCK_BIT   = 7;
  localparam int MODE_LSB   = 3;
  localparam logic [1:0] MODE_TOR = 2'b01;

  localparam int SEC_MML  = 0;
  localparam int SEC_MMWP = 1;
  localparam int SEC_RLB  = 2;
  localparam int SEC_W    = 3;

  typedef struct packed {
    logic secWr;
    logic rlbOk;
    logic rdCfg;
    logic rdAddr;
    logic rdSec;
  } strobe_t;

endpackage

// File: rtl/pmp_reg_ctrl.sv
module pmp_reg_ctrl
  import pmp_reg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             csrKind,
  input  logic [IDX_W-1:0]       csrIdx,
  input  logic [NUM_ENTRIES-1:0] lockVec,
  input  logic [NUM_ENTRIES-1:0] torVec,
  input  logic                   secRlb,
  output logic [NUM_ENTRIES-1:0] cfgEntWe,
  output logic [NUM_ENTRIES-1:0] addrEntWe,
  output strobe_t                stb,
  output logic                   flushPulse
);

  localparam int BPR  = XLEN / 8;
  localparam bit WIDE = (XLEN > 32);

  csrKind_e kind;
  logic oddIgnore, cfgWrite, addrWrite;
  logic [NUM_ENTRIES-1:0] torFreeze;
  int base;

  assign kind      = csrKind_e'(csrKind);
  assign oddIgnore = WIDE && csrIdx[0];
  assign cfgWrite  = wrEn && (kind == KIND_CFG) && !oddIgnore;
  assign addrWrite = wrEn && (kind == KIND_ADDR);
  assign base      = int'(csrIdx) * 4;

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gFreeze
      if (e < NUM_ENTRIES - 1) begin : gMid
        assign torFreeze[e] = lockVec[e+1] && torVec[e+1];
      end else begin : gTop
        assign torFreeze[e] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      cfgEntWe[e]  = cfgWrite && (e >= base) && (e < base + BPR) && !lockVec[e];
      addrEntWe[e] = addrWrite && (int'(csrIdx) == e) && !lockVec[e] && !torFreeze[e];
    end
  end

  always_comb begin
    stb.secWr  = wrEn && (kind == KIND_SEC);
    stb.rlbOk  = secRlb || !(|lockVec);
    stb.rdCfg  = (kind == KIND_CFG);
    stb.rdAddr = (kind == KIND_ADDR);
    stb.rdSec  = (kind == KIND_SEC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flushPulse <= 1'b0;
    else       flushPulse <= cfgWrite;
  end

  AST_ADDR_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(addrEntWe)); // R6

  AST_NO_FLUSH_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && kind != KIND_CFG) |=> !flushPulse); // R9

endmodule

// File: rtl/pmp_reg_data.sv
module pmp_reg_data
  import pmp_reg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDX_W-1:0]       csrIdx,
  input  logic [XLEN-1:0]        wrData,
  input  logic [NUM_ENTRIES-1:0] cfgEntWe,
  input  logic [NUM_ENTRIES-1:0] addrEntWe,
  input  strobe_t                stb,
  output logic [XLEN-1:0]        rdData,
  output logic [NUM_ENTRIES-1:0] lockVec,
  output logic [NUM_ENTRIES-1:0] torVec,
  output logic                   secRlb
);

  localparam int BPR = XLEN / 8;

  logic [NUM_ENTRIES*8-1:0]    cfgQ;
  logic [NUM_ENTRIES*8-1:0]    byteIn;
  logic [NUM_ENTRIES*XLEN-1:0] addrQ;
  logic [SEC_W-1:0]            secQ;
  int base;

  assign base = int'(csrIdx) * 4;

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gFlags
      assign lockVec[e] = cfgQ[e*8 + LOCK_BIT];
      assign torVec[e]  = (cfgQ[e*8 + MODE_LSB +: 2] == MODE_TOR);
    end
  endgenerate

  assign secRlb = secQ[SEC_RLB];

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      int slot;
      slot = e - base;
      if (slot >= 0 && slot < BPR) byteIn[e*8 +: 8] = wrData[slot*8 +: 8];
      else                         byteIn[e*8 +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      addrQ <= '0;
      secQ  <= '0;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (cfgEntWe[e])  cfgQ[e*8 +: 8]       <= byteIn[e*8 +: 8];
        if (addrEntWe[e]) addrQ[e*XLEN +: XLEN] <= wrData;
      end
      if (stb.secWr) begin
        secQ[SEC_RLB]  <= wrData[SEC_RLB] && stb.rlbOk;
        secQ[SEC_MMWP] <= wrData[SEC_MMWP] || secQ[SEC_MMWP];
        secQ[SEC_MML]  <= wrData[SEC_MML] || secQ[SEC_MML];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdCfg) begin
      for (int i = 0; i < BPR; i++) begin
        if (base + i < NUM_ENTRIES) rdData[i*8 +: 8] = cfgQ[(base + i)*8 +: 8];
      end
    end else if (stb.rdAddr) begin
      if (int'(csrIdx) < NUM_ENTRIES) rdData = addrQ[int'(csrIdx)*XLEN +: XLEN];
    end else if (stb.rdSec) begin
      rdData = {{(XLEN-SEC_W){1'b0}}, secQ};
    end
  end

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gChk
      AST_LOCKED_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
        lockVec[e] |=> $stable(cfgQ[e*8 +: 8])); // R3
      AST_LOCKED_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
        lockVec[e] |=> $stable(addrQ[e*XLEN +: XLEN])); // R4
      if (e < NUM_ENTRIES - 1) begin : gTorChk
        AST_TOR_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
          (lockVec[e+1] && torVec[e+1]) |=> $stable(addrQ[e*XLEN +: XLEN])); // R5
      end
    end
  endgenerate

  AST_MML_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    secQ[SEC_MML] |=> secQ[SEC_MML]); // R7
  AST_MMWP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    secQ[SEC_MMWP] |=> secQ[SEC_MMWP]); // R7
  AST_RLB_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!secQ[SEC_RLB] && (|lockVec)) |=> !secQ[SEC_RLB]); // R8

endmodule

// File: rtl/pmp_entry_regs.sv
module pmp_entry_regs
  import pmp_reg_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,
  parameter  int XLEN        = 32,
  localparam int IDX_W       = $clog2(NUM_ENTRIES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       csrKind,
  input  logic [IDX_W-1:0] csrIdx,
  input  logic [XLEN-1:0]  wrData,
  output logic [XLEN-1:0]  rdData,
  output logic             flushPulse
);

  logic [NUM_ENTRIES-1:0] lockVec, torVec, cfgEntWe, addrEntWe;
  logic    secRlb;
  strobe_t stb;

  initial begin
    assert (XLEN == 32 || XLEN == 64);
    assert (NUM_ENTRIES >= 1);
  end

  pmp_reg_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .csrKind(csrKind), .csrIdx(csrIdx),
    .lockVec(lockVec), .torVec(torVec), .secRlb(secRlb),
    .cfgEntWe(cfgEntWe), .addrEntWe(addrEntWe), .stb(stb), .flushPulse(flushPulse)
  );

  pmp_reg_data #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .csrIdx(csrIdx), .wrData(wrData),
    .cfgEntWe(cfgEntWe), .addrEntWe(addrEntWe), .stb(stb),
    .rdData(rdData), .lockVec(lockVec), .torVec(torVec), .secRlb(secRlb)
  );

endmodule

// File: tb/pmp_entry_regs_tb.sv
`timescale 1ns/1ps
module pmp_entry_regs_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        wrA = 0;  logic [1:0] kindA = 0; logic [4:0] idxA = 0;
  logic [31:0] dinA = 0; logic [31:0] doutA;    logic flushA;
  logic        wrB = 0;  logic [1:0] kindB = 0; logic [4:0] idxB = 0;
  logic [63:0] dinB = 0; logic [63:0] doutB;    logic flushB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pmp_entry_regs #(.NUM_ENTRIES(16), .XLEN(32)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrA), .csrKind(kindA), .csrIdx(idxA),
    .wrData(dinA), .rdData(doutA), .flushPulse(flushA));

  pmp_entry_regs #(.NUM_ENTRIES(16), .XLEN(64)) u_dut64 (
    .clk(clk), .rstN(rstN), .wrEn(wrB), .csrKind(kindB), .csrIdx(idxB),
    .wrData(dinB), .rdData(doutB), .flushPulse(flushB));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wrS(input logic [1:0] k, input int i, input logic [31:0] d, output logic fl);
    @(negedge clk); wrA = 1; kindA = k; idxA = 5'(i); dinA = d;
    @(negedge clk); wrA = 0; fl = flushA;
  endtask

  task automatic rdS(input logic [1:0] k, input int i, output logic [31:0] d);
    @(negedge clk); kindA = k; idxA = 5'(i); #1; d = doutA;
  endtask

  task automatic wrW(input logic [1:0] k, input int i, input logic [63:0] d, output logic fl);
    @(negedge clk); wrB = 1; kindB = k; idxB = 5'(i); dinB = d;
    @(negedge clk); wrB = 0; fl = flushB;
  endtask

  task automatic rdW(input logic [1:0] k, input int i, output logic [63:0] d);
    @(negedge clk); kindB = k; idxB = 5'(i); #1; d = doutB;
  endtask

  task automatic testReset();
    logic [31:0] v; logic [63:0] w;
    rdS(0, 0, v); chk("R10 cfg0", 64'(v), 0);
    rdS(1, 5, v); chk("R10 addr5", 64'(v), 0);
    rdS(2, 0, v); chk("R10 sec", 64'(v), 0);
    rdW(0, 2, w); chk("R10 cfg2 wide", w, 0);
  endtask

  task automatic testPackLock();
    logic [31:0] v; logic f;
    wrS(0, 1, 32'h44332211, f); chk("R9 flush on cfg write", 64'(f), 1);
    rdS(0, 1, v); chk("R1 cfg1 packed", 64'(v), 64'h44332211);
    rdS(0, 0, v); chk("R1 cfg0 untouched", 64'(v), 0);
    wrS(0, 0, 32'h00008000, f);
    wrS(0, 0, 32'h11111111, f); chk("R9 flush when locked", 64'(f), 1);
    rdS(0, 0, v); chk("R3 locked byte kept", 64'(v), 64'h11118011);
  endtask

  task automatic testAddr();
    logic [31:0] v; logic f;
    wrS(1, 3, 32'h1234, f); chk("R9 no flush on addr", 64'(f), 0);
    rdS(1, 3, v); chk("R4 addr3 written", 64'(v), 64'h1234);
    wrS(1, 1, 32'hBEEF, f);
    rdS(1, 1, v); chk("R4 locked addr dropped", 64'(v), 0);
    wrS(1, 0, 32'h77, f);
    rdS(1, 0, v); chk("R5 non-TOR neighbour allows", 64'(v), 64'h77);
  endtask

  task automatic testTor();
    logic [31:0] v; logic f;
    wrS(0, 2, 32'h90008800, f);
    wrS(1, 8, 32'hAAAA, f);
    rdS(1, 8, v); chk("R5 TOR neighbour freezes", 64'(v), 0);
    wrS(1, 10, 32'h55, f);
    rdS(1, 10, v); chk("R5 NA4 neighbour allows", 64'(v), 64'h55);
    wrS(0, 3, 32'h08000000, f);
    wrS(1, 15, 32'h99, f);
    rdS(1, 15, v); chk("R5 last entry writable", 64'(v), 64'h99);
  endtask

  task automatic testRange();
    logic [31:0] v; logic f;
    wrS(0, 4, 32'hFFFFFFFF, f);
    rdS(0, 4, v); chk("R6 cfg beyond entries", 64'(v), 0);
    rdS(0, 3, v); chk("R6 cfg3 unchanged", 64'(v), 64'h08000000);
    wrS(1, 16, 32'h1, f);
    rdS(1, 16, v); chk("R6 addr beyond entries", 64'(v), 0);
    rdS(1, 0, v); chk("R6 addr0 not aliased", 64'(v), 64'h77);
    wrS(3, 0, 32'hFFFF, f);
    rdS(3, 0, v); chk("R6 kind3 reads zero", 64'(v), 0);
    rdS(1, 0, v); chk("R6 kind3 write no effect", 64'(v), 64'h77);
  endtask

  task automatic testSec();
    logic [31:0] v; logic f;
    wrS(2, 0, 32'h7, f); chk("R9 no flush on sec", 64'(f), 0);
    rdS(2, 0, v); chk("R8 bypass blocked by lock", 64'(v), 64'h3);
    wrS(2, 0, 32'h0, f);
    rdS(2, 0, v); chk("R7 policy bits sticky", 64'(v), 64'h3);
  endtask

  task automatic testWide();
    logic [63:0] w; logic f;
    wrW(2, 0, 64'h4, f);
    rdW(2, 0, w); chk("R8 bypass set without locks", w, 64'h4);
    wrW(2, 0, 64'h0, f);
    rdW(2, 0, w); chk("R8 bypass cleared", w, 0);
    wrW(0, 1, 64'h1111111111111111, f); chk("R2 odd reg no flush", 64'(f), 0);
    rdW(0, 0, w); chk("R2 cfg0 unchanged", w, 0);
    rdW(0, 2, w); chk("R2 cfg2 unchanged", w, 0);
    wrW(0, 2, 64'h8807060504030201, f); chk("R9 wide flush", 64'(f), 1);
    rdW(0, 2, w); chk("R1 wide packing", w, 64'h8807060504030201);
    wrW(1, 14, 64'h5, f);
    rdW(1, 14, w); chk("R5 wide TOR freeze", w, 0);
    wrW(2, 0, 64'h4, f);
    rdW(2, 0, w); chk("R8 wide bypass blocked", w, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPackLock();
    testAddr();
    testTor();
    testRange();
    testSec();
    testWide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=hang exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule